// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block gives a processor two 32-bit memory-mapped words through which it reaches configuration registers that are not on its own bus. The word at offset 0x0 carries data in both directions. The word at offset 0x4 carries a command. Writing the command word launches one transaction. Reading the same word shows two hardware flags: one marks the operation as finished, and the other marks the returned data as valid.

Each command names its own target. When the local bit is set, the access goes to a small register bank inside the block and always completes after a fixed number of cycles. When the local bit is clear, the bridge sends a valid/ready request toward a remote hop. It then waits for a one-beat response. If the operation was a read, that response is copied into the data word.

For a write, software first loads the data word and then writes the command word. For a read, it writes the command word, polls until both flags are set, and then reads the data word.

Top module: `ind_cfg_bridge`

## Requirements
- R1: After reset, the data word and the command word both read as zero, and no remote request is pending.
- R2: The command word is laid out as follows: op in bits [3:0] (0 write, 1 read, 2 ID assignment, 3 circular write), local flag in bit 5, hop in bits [15:8], register offset in bits [21:16], space in bits [23:22]. A remote request presents this op and hop, an address of {space, offset}, and the data word as it stood when the command was written.
- R3: A command write that is accepted clears bit 6 (done) and bit 7 (data ready), whatever values were written to those bits. All other command bits read back exactly as written.
- R4: A local operation sets the done flag on the second clock edge after the command write is accepted, and not before.
- R5: Local op 1 reads the addressed register into the data word and sets both the done and data-ready flags. Ops 0, 2 and 3 store the data word into the register at space 0, offsets 0 to NREGS-1, and leave data ready at 0.
- R6: An access to space 3, or to an offset of NREGS or above, completes normally. A write there changes no register, and a read there returns zero.
- R7: A remote request keeps valid high and all its fields stable until ready is seen. After that, valid drops and the bridge waits for the response. Done is set on the edge where the response is valid.
- R8: A remote read loads the response into the data word and sets data ready. A remote write leaves the data word unchanged and data ready at 0.
- R9: A command write that arrives while an operation is in progress is ignored.
- R10: A bus write to offset 0x0 stores the value in the data word. A read at any offset other than 0x0 or 0x4 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | BUS_AW | Byte offset of the bus access |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational from bus_addr |
| rq_valid | output | 1 | Remote request valid |
| rq_ready | input | 1 | Remote request accepted |
| rq_op | output | 4 | Operation code of the request |
| rq_hop | output | 8 | Destination hop |
| rq_addr | output | 8 | {space, offset} of the target register |
| rq_data | output | 32 | Write payload of the request |
| rs_valid | input | 1 | Remote response valid |
| rs_data | input | 32 | Remote response data |

## Verification
A table of local commands exercises every op code. Together, the entries separate the following cases:
- a write from a read;
- mapped offsets from the top mapped offset;
- offsets just past the bank;
- the PHY space, which must not alias onto controller registers.

At each step the done flag is sampled one edge and two edges after launch, which tells an early completion apart from a late one.

Remote commands are held off with ready low so that field stability and the handling of a command write while busy can be observed. A remote write is then completed to show that the data word is left alone. Finally, a read with the flag bits set in the written command shows that those bits are cleared on launch and then set again on completion.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int DATA_W  = 32;
  localparam int TADDR_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOCAL = 2'd1,
    ST_REQ   = 2'd2,
    ST_RSP   = 2'd3
  } st_e;

  localparam logic [3:0] OP_READ = 4'd1;

  // Command word layout; bit positions are what software encodes.
  typedef struct packed {
    logic [7:0] spare_hi;
    logic [1:0] space;
    logic [5:0] offset;
    logic [7:0] hop;
    logic       rdy;
    logic       done;
    logic       is_local;
    logic       spare_b4;
    logic [3:0] op;
  } cmd_t;
endpackage

// File: rtl/cfgb_bank.sv
module cfgb_bank
  import cfgb_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [TADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  localparam int OFF_W = TADDR_W - 2;
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [DATA_W-1:0] regs_q [NREGS];
  logic [NREGS-1:0]  wsel;
  logic              hit;
  logic [IDX_W-1:0]  ridx;

  assign hit  = (addr[TADDR_W-1:OFF_W] == 2'b00) && (int'(addr[OFF_W-1:0]) < NREGS);
  assign ridx = addr[IDX_W-1:0];

  for (genvar g = 0; g < NREGS; g++) begin : g_sel
    assign wsel[g] = we && hit && (int'(addr[OFF_W-1:0]) == g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (wsel[i]) regs_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata = regs_q[ridx];
  end

  // R6
  bank_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel) && (!hit -> (wsel == '0)));
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
  import cfgb_pkg::*;
#(
  parameter int LOCAL_LAT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic [31:0]        cmd_wdata,
  input  logic [DATA_W-1:0]  data_q,
  output logic [31:0]        cmd_rd,
  output logic               busy,
  output logic               rq_valid,
  input  logic               rq_ready,
  output logic [3:0]         rq_op,
  output logic [7:0]         rq_hop,
  output logic [TADDR_W-1:0] rq_addr,
  output logic [DATA_W-1:0]  rq_data,
  input  logic               rs_valid,
  input  logic [DATA_W-1:0]  rs_data,
  output logic               bank_we,
  output logic [TADDR_W-1:0] bank_addr,
  output logic [DATA_W-1:0]  bank_wdata,
  input  logic [DATA_W-1:0]  bank_rdata,
  output logic               cap_en,
  output logic [DATA_W-1:0]  cap_data
);
  localparam int CNT_W = (LOCAL_LAT > 1) ? $clog2(LOCAL_LAT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCAL_LAT - 1);

  st_e               st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  cmd_t              cmd_q, cmd_d;
  logic [DATA_W-1:0] pay_q, pay_d;
  logic              launch, fin_loc, fin_rem, finish, is_rd;
  logic              cmd_en, cnt_en, pay_en;

  assign launch  = cmd_we && (st_q == ST_IDLE);
  assign fin_loc = (st_q == ST_LOCAL) && (cnt_q == LAST);
  assign fin_rem = (st_q == ST_RSP) && rs_valid;
  assign finish  = fin_loc || fin_rem;
  assign is_rd   = (cmd_q.op == OP_READ);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    cmd_d = cmd_q;
    pay_d = pay_q;
    case (st_q)
      ST_IDLE: begin
        if (cmd_we) begin
          cmd_d      = cmd_t'(cmd_wdata);
          cmd_d.done = 1'b0;
          cmd_d.rdy  = 1'b0;
          pay_d      = data_q;
          cnt_d      = '0;
          st_d       = cmd_d.is_local ? ST_LOCAL : ST_REQ;
        end
      end
      ST_LOCAL: begin
        if (fin_loc) st_d = ST_IDLE;
        else         cnt_d = cnt_q + 1'b1;
      end
      ST_REQ:  if (rq_ready) st_d = ST_RSP;
      ST_RSP:  if (rs_valid) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (finish) begin
      cmd_d.done = 1'b1;
      cmd_d.rdy  = is_rd;
    end
  end

  assign cmd_en = launch || finish;
  assign pay_en = launch;
  assign cnt_en = launch || (st_q == ST_LOCAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pay_q <= '0;
    else if (pay_en) pay_q <= pay_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cmd_rd     = cmd_q;
  assign busy       = (st_q != ST_IDLE);
  assign rq_valid   = (st_q == ST_REQ);
  assign rq_op      = cmd_q.op;
  assign rq_hop     = cmd_q.hop;
  assign rq_addr    = {cmd_q.space, cmd_q.offset};
  assign rq_data    = pay_q;
  assign bank_addr  = {cmd_q.space, cmd_q.offset};
  assign bank_wdata = pay_q;
  assign bank_we    = fin_loc && !is_rd;
  assign cap_en     = finish && is_rd;
  assign cap_data   = fin_loc ? bank_rdata : rs_data;

  // Checker state: cycles elapsed since the last launch, saturating.
  logic [15:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                age_q <= 16'hFFFF;
    else if (launch)           age_q <= '0;
    else if (age_q != 16'hFFFF) age_q <= age_q + 1'b1;
  end

  // R4
  local_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_q.done) && cmd_q.is_local) |-> (age_q == 16'(LOCAL_LAT)));
  // R7
  rq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_op) && $stable(rq_hop)
                                 && $stable(rq_addr) && $stable(rq_data)));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && busy) |=> ($stable(cmd_rd[31:8]) && $stable(cmd_rd[5:0])));
  // R8
  rdy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.rdy |-> cmd_q.done);
  // R2
  rq_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> !cmd_q.is_local);
endmodule

// File: rtl/ind_cfg_bridge.sv
module ind_cfg_bridge
  import cfgb_pkg::*;
#(
  parameter int NREGS     = 8,
  parameter int LOCAL_LAT = 2,
  parameter int BUS_AW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               rq_valid,
  input  logic               rq_ready,
  output logic [3:0]         rq_op,
  output logic [7:0]         rq_hop,
  output logic [TADDR_W-1:0] rq_addr,
  output logic [DATA_W-1:0]  rq_data,
  input  logic               rs_valid,
  input  logic [DATA_W-1:0]  rs_data
);
  localparam logic [BUS_AW-1:0] OFS_DATA = BUS_AW'(0);
  localparam logic [BUS_AW-1:0] OFS_CMD  = BUS_AW'(4);

  logic [DATA_W-1:0]  data_q, data_d;
  logic               data_en, cmd_we, busy;
  logic [31:0]        cmd_rd;
  logic               bank_we, cap_en;
  logic [TADDR_W-1:0] bank_addr;
  logic [DATA_W-1:0]  bank_wdata, bank_rdata, cap_data;

  assign cmd_we  = bus_we && (bus_addr == OFS_CMD);
  assign data_en = (bus_we && (bus_addr == OFS_DATA)) || cap_en;
  assign data_d  = cap_en ? cap_data : bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_DATA)     bus_rdata = data_q;
    else if (bus_addr == OFS_CMD) bus_rdata = cmd_rd;
  end

  cfgb_ctrl #(.LOCAL_LAT(LOCAL_LAT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_wdata  (bus_wdata),
    .data_q     (data_q),
    .cmd_rd     (cmd_rd),
    .busy       (busy),
    .rq_valid   (rq_valid),
    .rq_ready   (rq_ready),
    .rq_op      (rq_op),
    .rq_hop     (rq_hop),
    .rq_addr    (rq_addr),
    .rq_data    (rq_data),
    .rs_valid   (rs_valid),
    .rs_data    (rs_data),
    .bank_we    (bank_we),
    .bank_addr  (bank_addr),
    .bank_wdata (bank_wdata),
    .bank_rdata (bank_rdata),
    .cap_en     (cap_en),
    .cap_data   (cap_data)
  );

  cfgb_bank #(.NREGS(NREGS)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bank_we),
    .addr  (bank_addr),
    .wdata (bank_wdata),
    .rdata (bank_rdata)
  );

  // R10
  data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == OFS_DATA) && !cap_en) |=> (data_q == $past(bus_wdata)));
  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_we && !cap_en) |=> $stable(data_q));
endmodule

// File: tb/tb_ind_cfg_bridge.sv
module tb_ind_cfg_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rq_valid, rq_ready;
  logic [3:0]  rq_op;
  logic [7:0]  rq_hop, rq_addr;
  logic [31:0] rq_data;
  logic        rs_valid;
  logic [31:0] rs_data;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ind_cfg_bridge dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rq_valid(rq_valid),
    .rq_ready(rq_ready), .rq_op(rq_op), .rq_hop(rq_hop), .rq_addr(rq_addr),
    .rq_data(rq_data), .rs_valid(rs_valid), .rs_data(rs_data)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  sp;
    logic [5:0]  off;
    logic [31:0] din;
    logic [31:0] dexp;
    logic        rexp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 2'd0, 6'd1, 32'hA5A5_0001, 32'hA5A5_0001, 1'b0},
    '{4'd3, 2'd0, 6'd3, 32'h1234_5678, 32'h1234_5678, 1'b0},
    '{4'd2, 2'd0, 6'd7, 32'h0BAD_F00D, 32'h0BAD_F00D, 1'b0},
    '{4'd1, 2'd0, 6'd1, 32'h0000_0000, 32'hA5A5_0001, 1'b1},
    '{4'd1, 2'd0, 6'd3, 32'h0000_0000, 32'h1234_5678, 1'b1},
    '{4'd1, 2'd0, 6'd7, 32'hFFFF_0000, 32'h0BAD_F00D, 1'b1},
    '{4'd0, 2'd0, 6'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0},
    '{4'd1, 2'd0, 6'd8, 32'h7777_7777, 32'h0000_0000, 1'b1},
    '{4'd0, 2'd3, 6'd1, 32'h5555_5555, 32'h5555_5555, 1'b0},
    '{4'd1, 2'd3, 6'd1, 32'h6666_6666, 32'h0000_0000, 1'b1},
    '{4'd1, 2'd0, 6'd1, 32'h0000_0000, 32'hA5A5_0001, 1'b1},
    '{4'd1, 2'd0, 6'd0, 32'h9999_9999, 32'h0000_0000, 1'b1}
  };

  function automatic logic [31:0] mk_cmd(input logic [3:0] op, input logic loc,
                                         input logic [7:0] hop, input logic [1:0] sp,
                                         input logic [5:0] off);
    return {8'h00, sp, off, hop, 2'b00, loc, 1'b0, op};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL R7: actual=hung expected=run complete (watchdog)");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rq_ready = 1'b0; rs_valid = 1'b0; rs_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(4'h0, r); chk("R1 data word", r, 32'h0);
    bus_rd(4'h4, r); chk("R1 cmd word", r, 32'h0);
    chk("R1 rq_valid", {31'b0, rq_valid}, 32'h0);

    // Local table
    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [31:0] c;
      tag = ((VEC[i].sp != 2'd0) || (VEC[i].off >= 6'd8)) ? "R6" : "R5";
      bus_wr(4'h0, VEC[i].din);
      c = mk_cmd(VEC[i].op, 1'b1, 8'h00, VEC[i].sp, VEC[i].off);
      bus_wr(4'h4, c);
      bus_rd(4'h4, r); chk("R4 done after 1 edge", {31'b0, r[6]}, 32'h0);
      chk("R2 no remote req for local", {31'b0, rq_valid}, 32'h0);
      @(negedge clk);
      bus_rd(4'h4, r); chk("R4 done still low", {31'b0, r[6]}, 32'h0);
      @(negedge clk);
      bus_rd(4'h4, r); chk("R4 done at edge 2", {31'b0, r[6]}, 32'h1);
      chk({tag, " ready flag"}, {31'b0, r[7]}, {31'b0, VEC[i].rexp});
      chk("R3 cmd readback", r & 32'hFFFF_FF3F, c);
      bus_rd(4'h0, r); chk({tag, " data word"}, r, VEC[i].dexp);
    end

    // Remote write, held off by ready
    bus_wr(4'h0, 32'hDEAD_BEEF);
    bus_wr(4'h4, mk_cmd(4'd0, 1'b0, 8'h02, 2'd0, 6'd5));
    chk("R2 rq_valid", {31'b0, rq_valid}, 32'h1);
    chk("R2 rq_op", {28'b0, rq_op}, 32'h0);
    chk("R2 rq_hop", {24'b0, rq_hop}, 32'h2);
    chk("R2 rq_addr", {24'b0, rq_addr}, 32'h05);
    chk("R2 rq_data", rq_data, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    chk("R7 valid held", {31'b0, rq_valid}, 32'h1);
    chk("R7 rq_addr stable", {24'b0, rq_addr}, 32'h05);
    bus_rd(4'h4, r); chk("R7 not done while waiting", {31'b0, r[6]}, 32'h0);
    bus_wr(4'h4, mk_cmd(4'd1, 1'b1, 8'h00, 2'd0, 6'd1));
    bus_rd(4'h4, r); chk("R9 busy command ignored", r, mk_cmd(4'd0, 1'b0, 8'h02, 2'd0, 6'd5));
    chk("R9 request unchanged", {31'b0, rq_valid}, 32'h1);
    rq_ready = 1'b1;
    @(negedge clk);
    rq_ready = 1'b0;
    chk("R7 valid drops after ready", {31'b0, rq_valid}, 32'h0);
    bus_rd(4'h4, r); chk("R7 waits for response", {31'b0, r[6]}, 32'h0);
    rs_valid = 1'b1; rs_data = 32'h1111_2222;
    @(negedge clk);
    rs_valid = 1'b0;
    bus_rd(4'h4, r); chk("R7 done on response", {31'b0, r[6]}, 32'h1);
    chk("R8 write leaves ready low", {31'b0, r[7]}, 32'h0);
    bus_rd(4'h0, r); chk("R8 write keeps data word", r, 32'hDEAD_BEEF);

    // Remote read with flag bits set in the written word
    bus_wr(4'h4, 32'h00EA_01C1);
    bus_rd(4'h4, r); chk("R3 flags cleared on launch", r, 32'h00EA_0101);
    chk("R2 read rq_addr", {24'b0, rq_addr}, 32'hEA);
    chk("R2 read rq_op", {28'b0, rq_op}, 32'h1);
    chk("R2 read rq_hop", {24'b0, rq_hop}, 32'h1);
    rq_ready = 1'b1;
    @(negedge clk);
    rq_ready = 1'b0;
    rs_valid = 1'b1; rs_data = 32'hCAFE_F00D;
    @(negedge clk);
    rs_valid = 1'b0;
    bus_rd(4'h4, r); chk("R8 read done and ready", r, 32'h00EA_01C1);
    bus_rd(4'h0, r); chk("R8 read data captured", r, 32'hCAFE_F00D);

    // Data word and unused offsets
    bus_wr(4'h0, 32'h0F0F_1234);
    bus_rd(4'h0, r); chk("R10 data word write", r, 32'h0F0F_1234);
    bus_rd(4'h8, r); chk("R10 unused offset reads zero", r, 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule